// File: doc/BRIEF.md
# Paging Frame Timing Sequencer

This block is the frame-level controller of a paging receiver. Each input sample is one of four sliced FSK levels, taken at ten samples per 1600-baud bit. An external correlator compares the recent bit history against the known frame sync words. For every sample it reports whether a sync word matched, and for the matching word whether the rest of the frame runs at 3200 baud and whether it uses four levels. The sequencer turns these reports into a bit clock. It picks the sampling phase at the middle of the run of consecutive phases that matched. It shifts in the dotting and the frame information word at that phase. It then waits out the second header and gives a centre-sample strobe for every symbol in the fixed-length data portion. After that it returns to its idle defaults. A downstream decoder corrects errors in the information word and splits the data symbols into phases.

The machine has five states, with codes IDLE=0, SYNCING=1, SYNC1=2, SYNC2=3 and DATA=4. The transitions are:
- IDLE→SYNCING when sync is first matched.
- SYNCING→SYNC1 on the first sample with no match.
- SYNC1→SYNC2 after 48 bits.
- SYNC2→DATA after the header.
- DATA→IDLE when the data count is reached.
- Any state→IDLE on abort.

The phase index counts input samples modulo the current samples-per-bit value in every state. When the frame switches to 3200 baud, the phase index, the centre and the bit counter are all rescaled.

Top module: `pgr_frame_seq`

## Requirements
- R1: After reset, `state` is 0 (IDLE), `baud_fast` and `four_level` are 0, and `fiw_valid` and `data_stb` are 0.
- R2: In IDLE, a valid sample with `sync_hit` high moves the state to 1 (SYNCING). In SYNCING, the first valid sample with `sync_hit` low moves the state to 2 (SYNC1). The phase of the first matching sample is the start phase, and the phase of the first non-matching sample is the end phase. The phase is counted 0..9 from the reset or idle point, and the first valid sample after that point has phase 1.
- R3: The sampling centre is (start+end)/2 when start < end. Otherwise it is ((start+end)/2 + 5) mod 10.
- R4: In SYNC1 one bit is taken at each sample whose phase equals the centre. The bit is 1 when `smp_sym` > 1. On the 48th bit, `fiw` holds the last 32 bits with the earliest bit in bit 31, `fiw_valid` is high for exactly one cycle, and the state becomes 3 (SYNC2).
- R5: On entering SYNC2, `baud_fast` and `four_level` take the mode reported with the last matching sync sample.
- R6: At 1600 baud, the first data strobe comes 410 valid samples after the sample that completed the information word. At 3200 baud it comes 407 samples after: the phase becomes centre/2−2, the centre is halved, and the header count starts at −1 and runs to 80.
- R7: In DATA (state 4), `data_stb` pulses once every 10 samples at 1600 baud and every 5 samples at 3200 baud, and `data_sym` is the symbol of the sample that produced the strobe.
- R8: DATA ends after 2816 strobes at 1600 baud or 5632 strobes at 3200 baud. The state then returns to IDLE with `baud_fast` and `four_level` back at 0.
- R9: `abort` high on a clock edge returns the state to IDLE on that edge and suppresses any strobe or word pulse there.
- R10: A clock with `smp_valid` low changes neither the phase, the counters, the collected bits nor the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new oversampled symbol is present |
| smp_sym | input | 2 | Sliced symbol level 0..3 |
| sync_hit | input | 1 | Correlator reports a sync match for this sample |
| hit_fast | input | 1 | Matched word selects 3200 baud |
| hit_four | input | 1 | Matched word selects four-level data |
| abort | input | 1 | Synchronous return to IDLE |
| state | output | 3 | Current state code |
| fiw | output | 32 | Raw frame information word |
| fiw_valid | output | 1 | One-cycle pulse when `fiw` is complete |
| baud_fast | output | 1 | Frame body runs at 3200 baud |
| four_level | output | 1 | Frame body uses four levels |
| data_stb | output | 1 | Centre sample of a data symbol |
| data_sym | output | 2 | Symbol captured with `data_stb` |

## Verification
The bench covers the following centre cases:
- a run that wraps past phase 9;
- a run ending exactly at phase 0;
- a run covering all ten phases, where start equals end.

A midpoint calculation that ignores the wrap would sample on the inverse symbol and deliver the complemented word. The bench then times the header at both rates. It checks for 410 samples at 1600 baud and 407 at 3200 baud, so a missing index rescale, an unhalved centre or a header counter starting at 0 each shift the first data strobe. It also counts the data strobes to 2816 and 5632 and their spacing, inserts gaps in the sample stream during SYNC1, and aborts in the middle of DATA, where a leaked strobe would show.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SYNCING = 3'd1,
        ST_SYNC1   = 3'd2,
        ST_SYNC2   = 3'd3,
        ST_DATA    = 3'd4
    } pgr_state_e;
endpackage

// File: rtl/pgr_centre_calc.sv
// Modulo midpoint of a run of matching phases.
module pgr_centre_calc #(
    parameter int SPB = 10,
    parameter int PW  = 4
) (
    input  logic [PW-1:0] run_first,
    input  logic [PW-1:0] run_last,
    output logic [PW-1:0] centre
);
    localparam logic [PW:0] HALF_SPB = (PW+1)'(SPB / 2);
    localparam logic [PW:0] SPB_W    = (PW+1)'(SPB);

    logic [PW:0] sum_w;
    logic [PW:0] half_w;
    logic [PW:0] wrap_w;

    always_comb begin
        sum_w  = {1'b0, run_first} + {1'b0, run_last};
        half_w = sum_w >> 1;
        wrap_w = half_w + HALF_SPB;
        if (wrap_w >= SPB_W)
            wrap_w = wrap_w - SPB_W;
        if (run_first < run_last)
            centre = half_w[PW-1:0];
        else
            centre = wrap_w[PW-1:0];
    end
endmodule

// File: rtl/pgr_fiw_shift.sv
// Serial collector for the frame information word.
module pgr_fiw_shift #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (shift_en)
            word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/pgr_frame_seq.sv
module pgr_frame_seq
    import pgr_pkg::*;
#(
    parameter int SAMPLE_RATE = 16000,
    parameter int BASE_BAUD   = 1600,
    parameter int FIW_W       = 32,
    parameter int DOT_BITS    = 16,
    parameter int HDR_DIV     = 40,
    parameter int DATA_MS     = 1760
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [1:0]       smp_sym,
    input  logic             sync_hit,
    input  logic             hit_fast,
    input  logic             hit_four,
    input  logic             abort,
    output logic [2:0]       state,
    output logic [FIW_W-1:0] fiw,
    output logic             fiw_valid,
    output logic             baud_fast,
    output logic             four_level,
    output logic             data_stb,
    output logic [1:0]       data_sym
);
    localparam int FAST_BAUD  = 2 * BASE_BAUD;
    localparam int SPB_SLOW   = SAMPLE_RATE / BASE_BAUD;
    localparam int SPB_FAST   = SAMPLE_RATE / FAST_BAUD;
    localparam int SYNC1_BITS = DOT_BITS + FIW_W;
    localparam int HDR_SLOW   = BASE_BAUD / HDR_DIV;
    localparam int HDR_FAST   = FAST_BAUD / HDR_DIV;
    localparam int DATA_SLOW  = BASE_BAUD * DATA_MS / 1000;
    localparam int DATA_FAST  = FAST_BAUD * DATA_MS / 1000;
    localparam int PW         = $clog2(SPB_SLOW + 1);
    localparam int IW         = PW + 2;
    localparam int CW         = $clog2(DATA_FAST + 1) + 2;

    localparam logic signed [IW-1:0] ONE_I     = IW'(1);
    localparam logic signed [IW-1:0] SPB_S_I   = IW'(SPB_SLOW);
    localparam logic signed [IW-1:0] SPB_F_I   = IW'(SPB_FAST);
    localparam logic signed [IW-1:0] HALF_F_I  = IW'(SPB_FAST / 2);
    localparam logic signed [CW-1:0] ONE_C     = CW'(1);
    localparam logic signed [CW-1:0] MINUS1_C  = '1;
    localparam logic signed [CW-1:0] K_SYNC1   = CW'(SYNC1_BITS);
    localparam logic signed [CW-1:0] K_HDR_S   = CW'(HDR_SLOW);
    localparam logic signed [CW-1:0] K_HDR_F   = CW'(HDR_FAST);
    localparam logic signed [CW-1:0] K_DATA_S  = CW'(DATA_SLOW);
    localparam logic signed [CW-1:0] K_DATA_F  = CW'(DATA_FAST);

    pgr_state_e st_q, st_d;

    logic signed [IW-1:0] idx_q, idx_inc, idx_nxt, spb_cur, centre_q;
    logic signed [CW-1:0] cnt_q, cnt_inc, hdr_len, data_len;
    logic [PW-1:0]        start_q, centre_w;
    logic                 pend_fast_q, pend_four_q;
    logic                 fast_q, four_q;
    logic                 at_centre;
    logic                 sync1_done, sync2_done, data_done, go_idle;
    logic                 fiw_valid_q, data_stb_q;
    logic [1:0]           data_sym_q;

    // Phase arithmetic shared by every state
    always_comb begin
        spb_cur  = fast_q ? SPB_F_I : SPB_S_I;
        idx_inc  = idx_q + ONE_I;
        idx_nxt  = (idx_inc == spb_cur) ? '0 : idx_inc;
        at_centre = smp_valid && (idx_nxt == centre_q);
        cnt_inc  = cnt_q + ONE_C;
        hdr_len  = fast_q ? K_HDR_F : K_HDR_S;
        data_len = fast_q ? K_DATA_F : K_DATA_S;
        sync1_done = (st_q == ST_SYNC1) && at_centre && (cnt_inc == K_SYNC1);
        sync2_done = (st_q == ST_SYNC2) && at_centre && (cnt_inc == hdr_len);
        data_done  = (st_q == ST_DATA)  && at_centre && (cnt_inc == data_len);
        go_idle    = abort || data_done;
    end

    pgr_centre_calc #(.SPB(SPB_SLOW), .PW(PW)) u_centre (
        .run_first (start_q),
        .run_last  (idx_nxt[PW-1:0]),
        .centre    (centre_w)
    );

    pgr_fiw_shift #(.WORD_W(FIW_W)) u_fiw (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en ((st_q == ST_SYNC1) && at_centre && !abort),
        .bit_in   (smp_sym[1]),
        .word     (fiw)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d = ST_IDLE;
        end else if (smp_valid) begin
            unique case (st_q)
                ST_IDLE:    if (sync_hit)   st_d = ST_SYNCING;
                ST_SYNCING: if (!sync_hit)  st_d = ST_SYNC1;
                ST_SYNC1:   if (sync1_done) st_d = ST_SYNC2;
                ST_SYNC2:   if (sync2_done) st_d = ST_DATA;
                ST_DATA:    if (data_done)  st_d = ST_IDLE;
                default:                    st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Phase, centre, counters and mode
    always_ff @(posedge clk) begin
        if (!rst_n || go_idle) begin
            idx_q       <= '0;
            start_q     <= '0;
            centre_q    <= '0;
            cnt_q       <= '0;
            pend_fast_q <= 1'b0;
            pend_four_q <= 1'b0;
            fast_q      <= 1'b0;
            four_q      <= 1'b0;
        end else if (smp_valid) begin
            idx_q <= idx_nxt;
            unique case (st_q)
                ST_IDLE: begin
                    if (sync_hit) begin
                        start_q     <= idx_nxt[PW-1:0];
                        pend_fast_q <= hit_fast;
                        pend_four_q <= hit_four;
                    end
                end
                ST_SYNCING: begin
                    if (sync_hit) begin
                        pend_fast_q <= hit_fast;
                        pend_four_q <= hit_four;
                    end else begin
                        centre_q <= $signed({{(IW-PW){1'b0}}, centre_w});
                        cnt_q    <= '0;
                    end
                end
                ST_SYNC1: begin
                    if (sync1_done) begin
                        fast_q <= pend_fast_q;
                        four_q <= pend_four_q;
                        cnt_q  <= '0;
                        if (pend_fast_q) begin
                            centre_q <= centre_q >>> 1;
                            idx_q    <= (idx_nxt >>> 1) - HALF_F_I;
                            cnt_q    <= MINUS1_C;
                        end
                    end else if (at_centre) begin
                        cnt_q <= cnt_inc;
                    end
                end
                ST_SYNC2: begin
                    if (at_centre) cnt_q <= sync2_done ? '0 : cnt_inc;
                end
                ST_DATA: begin
                    if (at_centre) cnt_q <= cnt_inc;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiw_valid_q <= 1'b0;
            data_stb_q  <= 1'b0;
            data_sym_q  <= '0;
        end else begin
            fiw_valid_q <= sync1_done && !abort;
            data_stb_q  <= (st_q == ST_DATA) && at_centre && !abort;
            if ((st_q == ST_DATA) && at_centre && !abort)
                data_sym_q <= smp_sym;
        end
    end

    assign state      = st_q;
    assign fiw_valid  = fiw_valid_q;
    assign baud_fast  = fast_q;
    assign four_level = four_q;
    assign data_stb   = data_stb_q;
    assign data_sym   = data_sym_q;

    p_hit_enters_syncing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && smp_valid && sync_hit && !abort) |=> (st_q == ST_SYNCING));
    p_fiw_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiw_valid_q |=> !fiw_valid_q);
    p_fiw_lands_in_sync2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiw_valid_q |-> (st_q == ST_SYNC2));
    p_strobe_from_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_q |-> ($past(st_q) == ST_DATA));
    p_phase_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q < spb_cur);
    p_idle_defaults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (!fast_q && !four_q));
    p_abort_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (st_q == ST_IDLE && !data_stb_q && !fiw_valid_q));
    p_hold_without_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !abort) |=> ($stable(st_q) && $stable(cnt_q) && $stable(idx_q)));
endmodule

// File: tb/sim_pgr_frame_seq.sv
`timescale 1ns/1ps
module sim_pgr_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_sym = '0;
    logic        sync_hit = 1'b0;
    logic        hit_fast = 1'b0;
    logic        hit_four = 1'b0;
    logic        abort = 1'b0;
    logic [2:0]  state;
    logic [31:0] fiw;
    logic        fiw_valid, baud_fast, four_level, data_stb;
    logic [1:0]  data_sym;

    int checks = 0;
    int fails  = 0;
    int bp     = 0;

    always #4 clk = ~clk;

    pgr_frame_seq u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sym(smp_sym),
        .sync_hit(sync_hit), .hit_fast(hit_fast), .hit_four(hit_four), .abort(abort),
        .state(state), .fiw(fiw), .fiw_valid(fiw_valid), .baud_fast(baud_fast),
        .four_level(four_level), .data_stb(data_stb), .data_sym(data_sym)
    );

    // {start, end, centre, word}
    localparam logic [43:0] VEC [0:4] = '{
        {4'd3, 4'd8, 4'd5, 32'hA5C3_0F96},
        {4'd8, 4'd2, 4'd0, 32'h1234_5678},
        {4'd9, 4'd0, 4'd9, 32'hFFFF_0001},
        {4'd0, 4'd9, 4'd4, 32'h8000_7FFE},
        {4'd6, 4'd6, 4'd1, 32'h0F0F_F0F0}
    };

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic smp(input logic h, input logic [1:0] s);
        smp_valid = 1'b1;
        sync_hit  = h;
        smp_sym   = s;
        @(posedge clk);
        #1;
        bp = (bp + 1) % 10;
    endtask

    task automatic gap(input logic [1:0] s);
        smp_valid = 1'b0;
        sync_hit  = 1'b1;
        smp_sym   = s;
        @(posedge clk);
        #1;
        smp_valid = 1'b1;
    endtask

    task automatic run_sync(input int s, input int e, input logic f, input logic q);
        hit_fast = f;
        hit_four = q;
        while ((bp + 1) % 10 != s) smp(1'b0, 2'd0);
        smp(1'b1, 2'd0);
        chk(state == 3'd1, "R2 idle->syncing", 32'(state), 32'd1);
        while ((bp + 1) % 10 != e) smp(1'b1, 2'd0);
        hit_fast = 1'b0;
        hit_four = 1'b0;
        smp(1'b0, 2'd0);
        chk(state == 3'd2, "R2 syncing->sync1", 32'(state), 32'd2);
    endtask

    task automatic run_fiw(input int c, input logic [31:0] w, input logic with_gaps);
        logic early = 1'b0;
        for (int k = 0; k < 48; k++) begin
            logic b = (k < 16) ? ~k[0] : w[31 - (k - 16)];
            logic [1:0] on  = b ? 2'd3 : 2'd0;
            logic [1:0] off = b ? 2'd0 : 2'd3;
            while ((bp + 1) % 10 != c) smp(1'b0, off);
            if (with_gaps && k[0]) gap(off);
            smp(1'b0, on);
            if (k < 47) begin
                if (fiw_valid) early = 1'b1;
            end
        end
        chk(!early, "R4 no early fiw_valid", 32'(early), 32'd0);
        chk(fiw_valid == 1'b1, "R4 fiw_valid pulse", 32'(fiw_valid), 32'd1);
        chk(fiw == w, "R3/R4/R10 fiw word at centre", fiw, w);
        chk(state == 3'd3, "R4 enter sync2", 32'(state), 32'd3);
        smp(1'b0, 2'd0);
        chk(fiw_valid == 1'b0, "R4 fiw_valid one cycle", 32'(fiw_valid), 32'd0);
    endtask

    task automatic run_frame(input logic f, input logic q, input logic do_abort);
        int n = 0, cnt = 0, last = 0, gap_err = 0, sym_err = 0, first = -1;
        logic [1:0] prev;
        run_sync(2, 7, f, q);
        // the run 2..6 ends at 7, centre 4
        run_fiw(4, 32'hC0DE_1234, 1'b0);
        // one extra sample was spent checking the pulse
        n = 1;
        chk(baud_fast == f, "R5 baud from mode", 32'(baud_fast), 32'(f));
        chk(four_level == q, "R5 levels from mode", 32'(four_level), 32'(q));
        while (n < 40000) begin
            n++;
            prev = 2'(n % 4);
            smp(1'b0, prev);
            if (data_stb) begin
                cnt++;
                if (cnt == 1) first = n;
                else if (n - last != (f ? 5 : 10)) gap_err++;
                if (data_sym != prev) sym_err++;
                last = n;
            end
            if (do_abort && cnt == 20) break;
            if (state == 3'd0) break;
        end
        chk(first == (f ? 407 : 410), "R6 header length", 32'(first), f ? 32'd407 : 32'd410);
        chk(gap_err == 0, "R7 strobe spacing", 32'(gap_err), 32'd0);
        chk(sym_err == 0, "R7 strobe symbol", 32'(sym_err), 32'd0);
        if (do_abort) begin
            int leak = 0;
            abort = 1'b1;
            smp(1'b0, 2'd1);
            abort = 1'b0;
            chk(state == 3'd0, "R9 abort to idle", 32'(state), 32'd0);
            chk(data_stb == 1'b0, "R9 no strobe on abort", 32'(data_stb), 32'd0);
            for (int i = 0; i < 30; i++) begin
                smp(1'b0, 2'd2);
                if (data_stb || state != 3'd0) leak++;
            end
            chk(leak == 0, "R9 stays idle", 32'(leak), 32'd0);
        end else begin
            chk(cnt == (f ? 5632 : 2816), "R8 data strobe count", 32'(cnt), f ? 32'd5632 : 32'd2816);
            chk(state == 3'd0, "R8 back to idle", 32'(state), 32'd0);
            chk(baud_fast == 1'b0 && four_level == 1'b0, "R8 defaults restored",
                {30'd0, baud_fast, four_level}, 32'd0);
        end
        bp = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(state == 3'd0, "R1 reset state", 32'(state), 32'd0);
        chk(!baud_fast && !four_level, "R1 reset mode", {30'd0, baud_fast, four_level}, 32'd0);
        chk(!fiw_valid && !data_stb, "R1 reset pulses", {30'd0, fiw_valid, data_stb}, 32'd0);
        bp = 0;

        for (int v = 0; v < 5; v++) begin
            run_sync(int'(VEC[v][43:40]), int'(VEC[v][39:36]), 1'b0, 1'b0);
            run_fiw(int'(VEC[v][35:32]), VEC[v][31:0], v[0]);
            abort = 1'b1;
            smp(1'b0, 2'd0);
            abort = 1'b0;
            chk(state == 3'd0, "R9 abort from sync2", 32'(state), 32'd0);
            bp = 0;
        end

        run_frame(1'b0, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0);
        run_frame(1'b0, 1'b1, 1'b1);

        report();
        $finish;
    end

    initial begin
        #(190000 * 8);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end
endmodule